// File: doc/BRIEF.md
# Initiator Message-Out Sequencer

This block produces the byte stream an initiator sends while the target holds the bus in the message-out phase. When a pending code asks for an identify message, the block builds that byte from the logical unit number and the disconnect-privilege flag. It can follow the identify byte with a two-byte queue-tag message. If the pending code is an ordinary one-byte message, the block sends that byte alone. A reserved host code, or a make-message flag set alongside an identify, stops the sequence and waits for the host to supply the final byte.

Each byte leaves through a valid/ready handshake. The block samples the bus phase one cycle after every accepted byte. If the target has left message-out part-way through, the block stops. If the target is still in message-out after the last byte, the block raises attention again and repeats the whole sequence. When the sequence ends, attention is off, the sent code is kept as the last message, and a one-cycle pulse tells the owner of the pending register to load the no-op code.

Top module: `msgout_seq`

## Requirements
- R1: After reset, byte_valid_o, atn_o, done_o, host_wait_o and pend_clr_o are low, and last_msg_o is 0x08 (no-op).
- R2: A start_i pulse in idle raises atn_o on the next cycle. A pending code of 0x80 yields an identify byte equal to 0x80 | (disc_i << 6) | LUN. The LUN is lun_i[3:0] when wide_i is 1 and lun_i[2:0] when wide_i is 0, so lun_i[3] has no effect in narrow mode.
- R3: With identify, tag_en_i=1 and mk_msg_i=0, three bytes are sent in this order: identify, then 0x20 | tag_type_i[1:0], then tag_val_i. atn_o is high while the first two bytes are offered and low while the third is offered.
- R4: The phase is sampled one cycle after a non-final byte is accepted. If phase_mout_i is 0 at that point, the sequence completes without offering another byte.
- R5: A pending code other than 0x80 and 0xFF is sent as a single byte, unchanged, with atn_o low. With identify and tag_en_i=0, the identify byte alone is sent with atn_o low.
- R6: If phase_mout_i is still 1 one cycle after the final byte is accepted, atn_o returns high and the whole sequence repeats from the pending code.
- R7: Pending code 0xFF raises host_wait_o with no byte offered. On host_resume_i with host_phasemis_i=1, the sequence completes. Otherwise host_byte_i is sent as the final byte with atn_o low.
- R8: With identify and mk_msg_i=1, the identify byte is sent with atn_o high. The block then waits for the host exactly as in R7, without sampling the phase.
- R9: Completion shows as a one-cycle done_o and pend_clr_o pulse with atn_o low. On the following cycle, last_msg_o holds the pending code.
- R10: While byte_valid_o is high and byte_ready_i is low, byte_valid_o stays high and byte_o keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Message-out phase entered, begin sequence |
| pend_msg_i | input | 8 | Pending message code |
| wide_i | input | 1 | Wide mode: 4-bit LUN, else 3-bit |
| lun_i | input | 4 | Logical unit number |
| disc_i | input | 1 | Disconnect privilege |
| tag_en_i | input | 1 | Send queue-tag message after identify |
| tag_type_i | input | 2 | Queue-tag type |
| tag_val_i | input | 8 | Tag value |
| mk_msg_i | input | 1 | Hand to host after identify |
| phase_mout_i | input | 1 | Bus is in message-out phase |
| host_resume_i | input | 1 | Host done with awaited message |
| host_phasemis_i | input | 1 | Host saw a phase change |
| host_byte_i | input | 8 | Byte supplied by host |
| byte_ready_i | input | 1 | Byte accepted |
| byte_o | output | 8 | Outgoing message byte |
| byte_valid_o | output | 1 | byte_o is offered |
| atn_o | output | 1 | Attention request |
| host_wait_o | output | 1 | Awaiting host message |
| done_o | output | 1 | Sequence complete pulse |
| pend_clr_o | output | 1 | Load no-op into pending register |
| last_msg_o | output | 8 | Last message code sent |

## Verification
A corrupted state or byte-kind register shows up at byte_o or atn_o when the next byte is offered. Typical symptoms are a tag header with attention low, a tag value with attention high, or a missing or extra byte. These appear within a handshake or two. A wrong phase decision shows as a byte offered after the phase was dropped, or as a completion in place of the retry attention pulse, one cycle after the acceptance. A wrong identify composition shows directly in the first byte's value, for each wide/LUN/privilege combination.

// File: rtl/msgout_pkg.sv
package msgout_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_DECIDE, S_SEND, S_PCHK, S_HOST, S_DONE
  } state_e;

  // what the byte in flight is, selects the step after acceptance
  typedef enum logic [1:0] {
    K_ID_MK, K_ID_TAG, K_TAGHDR, K_FINAL
  } kind_e;
endpackage

// File: rtl/msgout_ident.sv
module msgout_ident #(
  parameter int unsigned      DW         = 8,
  parameter int unsigned      LUN_W      = 4,
  parameter int unsigned      DISC_BIT   = 6,
  parameter logic [DW-1:0]    IDENT_CODE = 8'h80
) (
  input  logic             wide_i,
  input  logic [LUN_W-1:0] lun_i,
  input  logic             disc_i,
  output logic [DW-1:0]    ident_o
);
  localparam int unsigned NARROW_W = LUN_W - 1;

  logic [DW-1:0] lun_ext;

  for (genvar j = 0; j < DW; j++) begin : g_bit
    if (j < NARROW_W) begin : g_narrow
      assign lun_ext[j] = lun_i[j];
    end else if (j < LUN_W) begin : g_wide
      assign lun_ext[j] = lun_i[j] & wide_i;
    end else begin : g_zero
      assign lun_ext[j] = 1'b0;
    end
  end

  assign ident_o = IDENT_CODE | (DW'(disc_i) << DISC_BIT) | lun_ext;
endmodule

// File: rtl/msgout_fsm.sv
module msgout_fsm
  import msgout_pkg::*;
#(
  parameter int unsigned   DW         = 8,
  parameter logic [DW-1:0] IDENT_CODE = 8'h80,
  parameter logic [DW-1:0] HOST_CODE  = 8'hFF,
  parameter logic [DW-1:0] NOOP_CODE  = 8'h08,
  parameter logic [DW-1:0] TAG_HDR    = 8'h20
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [DW-1:0] pend_msg_i,
  input  logic [DW-1:0] ident_i,
  input  logic          mk_msg_i,
  input  logic          tag_en_i,
  input  logic [1:0]    tag_type_i,
  input  logic [DW-1:0] tag_val_i,
  input  logic          phase_mout_i,
  input  logic          host_resume_i,
  input  logic          host_phasemis_i,
  input  logic [DW-1:0] host_byte_i,
  input  logic          byte_ready_i,
  output logic [DW-1:0] byte_o,
  output logic          byte_valid_o,
  output logic          atn_o,
  output logic          host_wait_o,
  output logic          done_o,
  output logic [DW-1:0] last_msg_o
);
  state_e        state_q, state_d;
  kind_e         kind_q, kind_d;
  logic [DW-1:0] byte_q, byte_d;
  logic          atn_q, atn_d;
  logic [DW-1:0] last_q;

  always_comb begin
    state_d = state_q;
    kind_d  = kind_q;
    byte_d  = byte_q;
    atn_d   = atn_q;
    unique case (state_q)
      S_IDLE: if (start_i) begin
        atn_d   = 1'b1;
        state_d = S_DECIDE;
      end
      S_DECIDE: begin
        if (pend_msg_i == IDENT_CODE) begin
          byte_d  = ident_i;
          state_d = S_SEND;
          if (mk_msg_i) begin
            kind_d = K_ID_MK;
          end else if (tag_en_i) begin
            kind_d = K_ID_TAG;
          end else begin
            kind_d = K_FINAL;
            atn_d  = 1'b0;
          end
        end else if (pend_msg_i == HOST_CODE) begin
          state_d = S_HOST;
        end else begin
          byte_d  = pend_msg_i;
          kind_d  = K_FINAL;
          atn_d   = 1'b0;
          state_d = S_SEND;
        end
      end
      S_SEND: if (byte_ready_i) state_d = (kind_q == K_ID_MK) ? S_HOST : S_PCHK;
      S_PCHK: begin
        if (!phase_mout_i) begin
          state_d = S_DONE;
        end else begin
          unique case (kind_q)
            K_ID_TAG: begin
              byte_d  = TAG_HDR | DW'(tag_type_i);
              kind_d  = K_TAGHDR;
              state_d = S_SEND;
            end
            K_TAGHDR: begin
              byte_d  = tag_val_i;
              kind_d  = K_FINAL;
              atn_d   = 1'b0;   // drop attention before the last byte
              state_d = S_SEND;
            end
            default: begin       // target kept message-out: retry all
              atn_d   = 1'b1;
              state_d = S_DECIDE;
            end
          endcase
        end
      end
      S_HOST: if (host_resume_i) begin
        if (host_phasemis_i) begin
          state_d = S_DONE;
        end else begin
          byte_d  = host_byte_i;
          kind_d  = K_FINAL;
          atn_d   = 1'b0;
          state_d = S_SEND;
        end
      end
      S_DONE:  state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
    if (state_d == S_DONE) atn_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      kind_q  <= K_FINAL;
      byte_q  <= '0;
      atn_q   <= 1'b0;
      last_q  <= NOOP_CODE;
    end else begin
      state_q <= state_d;
      kind_q  <= kind_d;
      byte_q  <= byte_d;
      atn_q   <= atn_d;
      if (state_q == S_DONE) last_q <= pend_msg_i;
    end
  end

  assign byte_o       = byte_q;
  assign byte_valid_o = (state_q == S_SEND);
  assign atn_o        = atn_q;
  assign host_wait_o  = (state_q == S_HOST);
  assign done_o       = (state_q == S_DONE);
  assign last_msg_o   = last_q;
endmodule

// File: rtl/msgout_seq.sv
module msgout_seq #(
  parameter int unsigned   DW         = 8,
  parameter int unsigned   LUN_W      = 4,
  parameter int unsigned   DISC_BIT   = 6,
  parameter logic [DW-1:0] IDENT_CODE = 8'h80,
  parameter logic [DW-1:0] HOST_CODE  = 8'hFF,
  parameter logic [DW-1:0] NOOP_CODE  = 8'h08,
  parameter logic [DW-1:0] TAG_HDR    = 8'h20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [DW-1:0]    pend_msg_i,
  input  logic             wide_i,
  input  logic [LUN_W-1:0] lun_i,
  input  logic             disc_i,
  input  logic             tag_en_i,
  input  logic [1:0]       tag_type_i,
  input  logic [DW-1:0]    tag_val_i,
  input  logic             mk_msg_i,
  input  logic             phase_mout_i,
  input  logic             host_resume_i,
  input  logic             host_phasemis_i,
  input  logic [DW-1:0]    host_byte_i,
  input  logic             byte_ready_i,
  output logic [DW-1:0]    byte_o,
  output logic             byte_valid_o,
  output logic             atn_o,
  output logic             host_wait_o,
  output logic             done_o,
  output logic             pend_clr_o,
  output logic [DW-1:0]    last_msg_o
);
  logic [DW-1:0] ident;
  logic          done;

  msgout_ident #(
    .DW(DW), .LUN_W(LUN_W), .DISC_BIT(DISC_BIT), .IDENT_CODE(IDENT_CODE)
  ) i_ident (
    .wide_i (wide_i),
    .lun_i  (lun_i),
    .disc_i (disc_i),
    .ident_o(ident)
  );

  msgout_fsm #(
    .DW(DW), .IDENT_CODE(IDENT_CODE), .HOST_CODE(HOST_CODE),
    .NOOP_CODE(NOOP_CODE), .TAG_HDR(TAG_HDR)
  ) i_fsm (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .start_i        (start_i),
    .pend_msg_i     (pend_msg_i),
    .ident_i        (ident),
    .mk_msg_i       (mk_msg_i),
    .tag_en_i       (tag_en_i),
    .tag_type_i     (tag_type_i),
    .tag_val_i      (tag_val_i),
    .phase_mout_i   (phase_mout_i),
    .host_resume_i  (host_resume_i),
    .host_phasemis_i(host_phasemis_i),
    .host_byte_i    (host_byte_i),
    .byte_ready_i   (byte_ready_i),
    .byte_o         (byte_o),
    .byte_valid_o   (byte_valid_o),
    .atn_o          (atn_o),
    .host_wait_o    (host_wait_o),
    .done_o         (done),
    .last_msg_o     (last_msg_o)
  );

  assign done_o     = done;
  assign pend_clr_o = done;
endmodule

// File: rtl/msgout_seq_chk.sv
module msgout_seq_chk #(
  parameter int unsigned DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [DW-1:0] pend_msg_i,
  input logic          byte_ready_i,
  input logic [DW-1:0] byte_o,
  input logic          byte_valid_o,
  input logic          atn_o,
  input logic          host_wait_o,
  input logic          done_o,
  input logic [DW-1:0] last_msg_o
);
  p_valid_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_valid_o && !byte_ready_i |=> byte_valid_o && $stable(byte_o));

  p_atn_off_done_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !atn_o);

  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_last_msg_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> last_msg_o == $past(pend_msg_i));

  p_no_byte_host_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_wait_o |-> !byte_valid_o);

  p_one_activity_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({byte_valid_o, host_wait_o, done_o}));
endmodule

bind msgout_seq msgout_seq_chk #(.DW(DW)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .pend_msg_i  (pend_msg_i),
  .byte_ready_i(byte_ready_i),
  .byte_o      (byte_o),
  .byte_valid_o(byte_valid_o),
  .atn_o       (atn_o),
  .host_wait_o (host_wait_o),
  .done_o      (done_o),
  .last_msg_o  (last_msg_o)
);

// File: tb/test_msgout_seq.sv
module test_msgout_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [7:0] pend = 8'h08;
  logic       wide = 1'b0;
  logic [3:0] lun = '0;
  logic       disc = 1'b0;
  logic       tag_en = 1'b0;
  logic [1:0] tag_type = '0;
  logic [7:0] tag_val = '0;
  logic       mk_msg = 1'b0;
  logic       phase = 1'b1;
  logic       resume = 1'b0;
  logic       hmis = 1'b0;
  logic [7:0] hbyte = '0;
  logic       ready = 1'b0;
  logic [7:0] byte_o;
  logic       valid, atn, hwait, done, pclr;
  logic [7:0] last_msg;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  msgout_seq i_msgout_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .pend_msg_i(pend),
    .wide_i(wide), .lun_i(lun), .disc_i(disc), .tag_en_i(tag_en),
    .tag_type_i(tag_type), .tag_val_i(tag_val), .mk_msg_i(mk_msg),
    .phase_mout_i(phase), .host_resume_i(resume), .host_phasemis_i(hmis),
    .host_byte_i(hbyte), .byte_ready_i(ready), .byte_o(byte_o),
    .byte_valid_o(valid), .atn_o(atn), .host_wait_o(hwait), .done_o(done),
    .pend_clr_o(pclr), .last_msg_o(last_msg)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_for_valid(output bit ok);
    ok = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (valid) begin ok = 1; break; end
      if (done || hwait) break;
    end
  endtask

  task automatic expect_byte(input string req, input logic [7:0] eb, input logic ea, input bit ph);
    bit ok;
    wait_for_valid(ok);
    chk({req, " byte offered"}, {31'd0, ok}, 32'd1);
    if (!ok) return;
    chk({req, " byte"}, {24'd0, byte_o}, {24'd0, eb});
    chk({req, " atn"}, {31'd0, atn}, {31'd0, ea});
    @(negedge clk);
    chk("R10 hold", {23'd0, valid, byte_o}, {23'd0, 1'b1, eb});
    ready = 1'b1;
    phase = ph;
    @(negedge clk);
    ready = 1'b0;
  endtask

  task automatic expect_host(input string req);
    bit ok = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (hwait) begin ok = 1; break; end
      if (valid || done) break;
    end
    chk({req, " host wait"}, {30'd0, ok, valid}, {30'd0, 1'b1, 1'b0});
    resume = 1'b1;
    @(negedge clk);
    resume = 1'b0;
  endtask

  task automatic expect_done(input logic [7:0] p);
    bit ok = 0;
    for (int i = 0; i < 60; i++) begin
      if (done) begin ok = 1; break; end
      if (valid || hwait) break;
      @(negedge clk);
    end
    chk("R9 done", {28'd0, ok, atn, pclr, valid}, {28'd0, 1'b1, 1'b0, 1'b1, 1'b0});
    @(negedge clk);
    chk("R9 last msg", {23'd0, done, last_msg}, {23'd0, 1'b0, p});
  endtask

  function automatic logic [7:0] ident_of(bit w, logic [3:0] l, bit d);
    return 8'h80 | (d ? 8'h40 : 8'h00) | (w ? {4'd0, l} : {5'd0, l[2:0]});
  endfunction

  task automatic run(input logic [7:0] p, input bit w, input logic [3:0] l, input bit d,
                     input bit te, input logic [1:0] tt, input logic [7:0] tv, input bit mk,
                     input int abort_at, input int retry, input logic [7:0] hb, input bit hm);
    int nb = 0;
    int fc = 0;
    bit ph;
    logic [7:0] fin;
    @(negedge clk);
    pend = p; wide = w; lun = l; disc = d; tag_en = te; tag_type = tt;
    tag_val = tv; mk_msg = mk; hbyte = hb; hmis = hm; phase = 1'b1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R2 atn after start", {31'd0, atn}, 32'd1);
    forever begin
      if (p == 8'h80) begin
        if (mk) begin
          expect_byte("R8 ident", ident_of(w, l, d), 1'b1, 1'b1);
          expect_host("R8");
          if (hm) break;
          fin = hb;
        end else if (te) begin
          ph = (nb != abort_at); nb++;
          expect_byte("R3 ident", ident_of(w, l, d), 1'b1, ph);
          if (!ph) break;
          ph = (nb != abort_at); nb++;
          expect_byte("R3 tag hdr", 8'h20 | {6'd0, tt}, 1'b1, ph);
          if (!ph) break;
          fin = tv;
        end else begin
          fin = ident_of(w, l, d);
        end
      end else if (p == 8'hFF) begin
        expect_host("R7");
        if (hm) break;
        fin = hb;
      end else begin
        fin = p;
      end
      ph = (fc < retry);
      fc++;
      expect_byte("R5 final", fin, 1'b0, ph);
      if (!ph) break;
      @(negedge clk);
      chk("R6 atn reasserted", {31'd0, atn}, 32'd1);
    end
    expect_done(p);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset", {20'd0, valid, atn, done, hwait, pclr, 3'd0, last_msg},
        {20'd0, 5'b00000, 3'd0, 8'h08});
    rst_n = 1'b1;
    @(negedge clk);
    // identify sweep: plain, tagged (three types), host handoff
    for (int w = 0; w < 2; w++)
      for (int l = 0; l < 16; l++)
        for (int d = 0; d < 2; d++)
          for (int m = 0; m < 5; m++)
            run(8'h80, w[0], l[3:0], d[0], (m >= 1 && m <= 3), 2'(m - 1), 8'(l * 16 + m),
                (m == 4), -1, 0, 8'(8'h40 + l), 1'b0);
    // R4 abort after identify and after tag header
    run(8'h80, 1'b1, 4'd5, 1'b1, 1'b1, 2'd1, 8'hA5, 1'b0, 0, 0, 8'h00, 1'b0);
    run(8'h80, 1'b0, 4'd3, 1'b0, 1'b1, 2'd2, 8'h5A, 1'b0, 1, 0, 8'h00, 1'b0);
    // R6 retries
    run(8'h06, 1'b0, 4'd0, 1'b0, 1'b0, 2'd0, 8'h00, 1'b0, -1, 2, 8'h00, 1'b0);
    run(8'h80, 1'b1, 4'd9, 1'b0, 1'b1, 2'd0, 8'h3C, 1'b0, -1, 1, 8'h00, 1'b0);
    run(8'hFF, 1'b0, 4'd0, 1'b0, 1'b0, 2'd0, 8'h00, 1'b0, -1, 1, 8'h0D, 1'b0);
    // R7 host code, R8 host phase miss
    run(8'hFF, 1'b0, 4'd0, 1'b0, 1'b0, 2'd0, 8'h00, 1'b0, -1, 0, 8'h0C, 1'b0);
    run(8'hFF, 1'b0, 4'd0, 1'b0, 1'b0, 2'd0, 8'h00, 1'b0, -1, 0, 8'h0C, 1'b1);
    run(8'h80, 1'b1, 4'd7, 1'b1, 1'b1, 2'd0, 8'h00, 1'b1, -1, 0, 8'h00, 1'b1);
    // R5 every one-byte code
    for (int v = 0; v < 256; v++)
      if (v != 8'h80 && v != 8'hFF)
        run(8'(v), 1'b0, 4'd0, 1'b0, 1'b0, 2'd0, 8'h00, 1'b0, -1, 0, 8'h00, 1'b0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule